// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block drives a single PWM pin from an 8-bit period timer that runs behind a selectable prescaler. The period is set by an 8-bit limit register. The duty value is 10 bits wide: an 8-bit upper part and a 2-bit lower part. The duty comparison extends the timer with a 2-bit sub-count. The sub-count is the input-clock phase at prescale 1, or two bits of the prescaler counter at prescale 4 and 16. Duty steps are therefore four times finer than timer steps.

The upper and lower duty fields come straight from software-written registers. The generator keeps its own copy of them, refreshed only at the start of each period. A value written partway through a period therefore cannot shorten or stretch the pulse in progress.

There is no streaming data path. Every input is a plain level-sensitive control, sampled on each clock, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_fine_gen`

## Requirements
- R1: The output period, measured between rising edges, is (period register + 1) × 4 × prescale input clocks.
- R2: For 0 < duty < (period register + 1) × 4, the output is high for exactly duty × prescale input clocks in each period, where duty = {upper part, lower part}.
- R3: Prescale select encoding: 2'b00 divides by 1, 2'b01 divides by 4, 2'b10 and 2'b11 divide by 16.
- R4: A duty value written while a period is running leaves the current pulse unchanged. It takes effect from the next period start.
- R5: A duty of 0 keeps the output low through the whole period, with no one-clock pulse at the period start.
- R6: A duty of at least (period register + 1) × 4 keeps the output high continuously.
- R7: While the PWM enable is low, the output is driven low from the next clock on, and the timer is held at zero.
- R8: While the PWM enable is high and the timer enable is low, the output and the timer hold their values.
- R9: The output rises only on a period boundary, the clock on which the timer wraps from the period value to zero.
- R10: After reset the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_en | input | 1 | PWM mode enable; low forces the output low and clears the counters |
| tmr_en | input | 1 | Timer run enable; low freezes the timer and sub-count |
| period_lim | input | 8 | Period register; the timer wraps after reaching this value |
| duty_hi | input | 8 | Upper 8 bits of the software duty value |
| duty_lo | input | 2 | Lower 2 bits of the software duty value |
| presc_sel | input | 2 | Prescale select (see R3) |
| pwm_out | output | 1 | PWM output pin |

## Verification
On every cycle, the assertions check these properties:
- the disabled state forces a low output and a zero timer;
- the frozen state holds the output and the timer;
- a rising edge appears only after a period boundary;
- a zero duty never produces a set pulse;
- the internal duty copy changes only on a boundary.

Pulse width and period in input clocks, the effect of each prescale code, and the deferral of a mid-period duty write are arithmetic over many cycles. Only the bench's sweeps over duty, period and prescale can show them.

// File: rtl/pwm_fine_pkg.sv
package pwm_fine_pkg;

  // Prescale select codes (R3)
  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV4   = 2'b01,
    PS_DIV16  = 2'b10,
    PS_DIV16X = 2'b11
  } ps_sel_e;

  localparam int SUB_W = 2;
  localparam int PRE_W = 4;

  // Highest prescaler count before wrap, per select code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      PS_DIV1:  pre_limit = 4'd0;
      PS_DIV4:  pre_limit = 4'd3;
      default:  pre_limit = 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_fine_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [1:0]       sel,
  output logic [SUB_W-1:0] ext,
  output logic             unit_end,
  output logic             tick
);

  logic [1:0]       phase_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             phase_wrap;
  logic             pre_wrap;

  assign lim        = pre_limit(sel);
  assign phase_wrap = (phase_q == 2'd3);
  assign pre_wrap   = (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pre_q   <= '0;
    end else if (!run) begin
      phase_q <= '0;
      pre_q   <= '0;
    end else if (adv) begin
      phase_q <= phase_q + 2'd1;
      if (phase_wrap)
        pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
    end
  end

  // The sub-count and the end of each sub-count step depend on the prescale
  always_comb begin
    case (sel)
      PS_DIV1: begin
        ext      = phase_q;
        unit_end = adv;
      end
      PS_DIV4: begin
        ext      = pre_q[1:0];
        unit_end = adv && phase_wrap;
      end
      default: begin
        ext      = pre_q[3:2];
        unit_end = adv && phase_wrap && (pre_q[1:0] == 2'd3);
      end
    endcase
  end

  assign tick = run && adv && phase_wrap && pre_wrap;

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [TMR_W-1:0] period_lim,
  output logic [TMR_W-1:0] tmr,
  output logic             boundary
);

  logic [TMR_W-1:0] tmr_q;

  assign boundary = tick && (tmr_q == period_lim);
  assign tmr      = tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr_q <= '0;
    else if (!run)     tmr_q <= '0;
    else if (boundary) tmr_q <= '0;
    else if (tick)     tmr_q <= tmr_q + 1'b1;
  end

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] duty_act
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_act <= '0;
    else if (load) duty_act <= duty_in;
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   boundary,
  input  logic                   unit_end,
  input  logic [TMR_W-1:0]       tmr,
  input  logic [SUB_W-1:0]       ext,
  input  logic [TMR_W+SUB_W-1:0] duty_act,
  input  logic                   duty_new_zero,
  output logic                   pwm_o
);

  localparam int DUTY_W = TMR_W + SUB_W;

  logic [DUTY_W:0] cnt_next;
  logic            clear_hit;

  // Clear on the edge where the extended count would reach the duty
  assign cnt_next  = {1'b0, tmr, ext} + 1'b1;
  assign clear_hit = unit_end && (cnt_next == {1'b0, duty_act});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pwm_o <= 1'b0;
    else if (!run)      pwm_o <= 1'b0;
    else if (boundary)  pwm_o <= !duty_new_zero;
    else if (clear_hit) pwm_o <= 1'b0;
  end

endmodule

// File: rtl/pwm_fine_gen.sv
module pwm_fine_gen
  import pwm_fine_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_en,
  input  logic             tmr_en,
  input  logic [TMR_W-1:0] period_lim,
  input  logic [TMR_W-1:0] duty_hi,
  input  logic [1:0]       duty_lo,
  input  logic [1:0]       presc_sel,
  output logic             pwm_out
);

  localparam int DUTY_W = TMR_W + SUB_W;

  logic [SUB_W-1:0]  ext;
  logic              unit_end;
  logic              tick;
  logic [TMR_W-1:0]  tmr_q;
  logic              boundary;
  logic [DUTY_W-1:0] duty_sw;
  logic [DUTY_W-1:0] duty_act;

  assign duty_sw = {duty_hi, duty_lo};

  pwm_phase_gen u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (pwm_en),
    .adv      (tmr_en),
    .sel      (presc_sel),
    .ext      (ext),
    .unit_end (unit_end),
    .tick     (tick)
  );

  pwm_period_timer #(.TMR_W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (pwm_en),
    .tick       (tick),
    .period_lim (period_lim),
    .tmr        (tmr_q),
    .boundary   (boundary)
  );

  pwm_duty_buf #(.DUTY_W(DUTY_W)) u_dbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .duty_in  (duty_sw),
    .duty_act (duty_act)
  );

  pwm_out_stage #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (pwm_en),
    .boundary      (boundary),
    .unit_end      (unit_end),
    .tmr           (tmr_q),
    .ext           (ext),
    .duty_act      (duty_act),
    .duty_new_zero (duty_sw == '0),
    .pwm_o         (pwm_out)
  );

endmodule

// File: rtl/pwm_fine_chk.sv
module pwm_fine_chk #(
  parameter int TMR_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pwm_en,
  input logic                 tmr_en,
  input logic                 pwm_out,
  input logic                 boundary,
  input logic [TMR_W-1:0]     tmr,
  input logic [TMR_W+1:0]     duty_act,
  input logic [TMR_W+1:0]     duty_new
);

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pwm_out);

  // R7
  disabled_tmr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> (tmr == '0));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !tmr_en) |=> ($stable(pwm_out) && $stable(tmr)));

  // R9
  rise_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(boundary));

  // R5
  zero_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && duty_new == '0) |=> !pwm_out);

  // R4
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(duty_act));

  // R10
  always_comb if (!rst_n) reset_low_chk: assert (!pwm_out);

endmodule

bind pwm_fine_gen pwm_fine_chk #(.TMR_W(TMR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_en   (pwm_en),
  .tmr_en   (tmr_en),
  .pwm_out  (pwm_out),
  .boundary (boundary),
  .tmr      (tmr_q),
  .duty_act (duty_act),
  .duty_new (duty_sw)
);

// File: tb/pwm_fine_gen_bench.sv
module pwm_fine_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_en = 1'b0;
  logic       tmr_en = 1'b0;
  logic [7:0] period_lim = '0;
  logic [7:0] duty_hi = '0;
  logic [1:0] duty_lo = '0;
  logic [1:0] presc_sel = '0;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pwm_fine_gen u_pwm_fine_gen (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .tmr_en(tmr_en),
    .period_lim(period_lim), .duty_hi(duty_hi), .duty_lo(duty_lo),
    .presc_sel(presc_sel), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = d[9:2];
    duty_lo = d[1:0];
  endtask

  function automatic int ps_of(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
  endfunction

  // Wait for a rising edge, then measure the high time and the full period.
  // When wr_at > 0, new_d is written after wr_at high samples.
  task automatic measure(input int wr_at, input int new_d, output int hi, output int per);
    bit prev;
    int lo;
    int guard;
    hi = 0; per = 0; lo = 0;
    prev = pwm_out;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (!prev && pwm_out) break;
      prev = pwm_out;
      if (guard > 20000) return;
    end
    hi = 1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (!pwm_out) break;
      hi++;
      if (wr_at > 0 && hi == wr_at) set_duty(new_d);
      if (guard > 20000) return;
    end
    lo = 1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (pwm_out) break;
      lo++;
      if (guard > 20000) return;
    end
    per = hi + lo;
  endtask

  task automatic sweep(input logic [1:0] sel, input int p);
    int ps;
    int hi;
    int per;
    ps = ps_of(sel);
    presc_sel = sel;
    period_lim = p[7:0];
    for (int d = 1; d < (p + 1) * 4; d++) begin
      set_duty(d);
      measure(0, 0, hi, per);
      // R2 high time, R3 prescale decode
      check(hi == d * ps, $sformatf("R2/R3 hi sel=%0d p=%0d d=%0d", sel, p, d), hi, d * ps);
      // R1 period
      check(per == (p + 1) * 4 * ps, $sformatf("R1 per sel=%0d p=%0d d=%0d", sel, p, d),
            per, (p + 1) * 4 * ps);
    end
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hi;
    int per;
    int cnt;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(pwm_out == 1'b0, "R10 reset out", pwm_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R10 after reset", pwm_out, 0);
    pwm_en = 1'b1;
    tmr_en = 1'b1;

    sweep(2'b00, 3);
    sweep(2'b00, 7);
    sweep(2'b01, 3);
    sweep(2'b01, 7);
    sweep(2'b10, 3);
    sweep(2'b11, 1);

    // R4 mid-period write: current pulse unchanged, next uses new value
    presc_sel = 2'b00;
    period_lim = 8'd7;
    set_duty(20);
    measure(0, 0, hi, per);
    measure(5, 9, hi, per);
    check(hi == 20, "R4 pulse kept", hi, 20);
    measure(0, 0, hi, per);
    check(hi == 9, "R4 new duty applied", hi, 9);
    presc_sel = 2'b01;
    measure(0, 0, hi, per);
    measure(10, 30, hi, per);
    check(hi == 36, "R4 pulse kept div4", hi, 36);
    measure(0, 0, hi, per);
    check(hi == 120, "R4 new duty div4", hi, 120);

    // R5 zero duty: no high sample over several periods
    presc_sel = 2'b00;
    set_duty(0);
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
    check(cnt == 0, "R5 zero duty high samples", cnt, 0);

    // R6 duty at and beyond the period: stays high
    set_duty(32);
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!pwm_out) cnt++;
    end
    check(cnt == 0, "R6 duty=full low samples", cnt, 0);
    set_duty(1000);
    repeat (40) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!pwm_out) cnt++;
    end
    check(cnt == 0, "R6 duty>period low samples", cnt, 0);

    // R8 timer enable low freezes output while high
    set_duty(16);
    measure(0, 0, hi, per);
    @(negedge clk);
    while (!pwm_out) @(negedge clk);
    tmr_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!pwm_out) cnt++;
    end
    check(cnt == 0, "R8 frozen output", cnt, 0);
    tmr_en = 1'b1;
    measure(0, 0, hi, per);
    check(hi == 16, "R8 resume hi", hi, 16);

    // R7 disable forces low next cycle
    @(negedge clk);
    while (!pwm_out) @(negedge clk);
    pwm_en = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 disabled low", pwm_out, 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
    check(cnt == 0, "R7 stays low", cnt, 0);
    pwm_en = 1'b1;
    measure(0, 0, hi, per);
    measure(0, 0, hi, per);
    check(per == 32, "R7 restart period", per, 32);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule